// File: doc/BRIEF.md
# Three-Level Min-Max Duty Calculator

This block turns one sample of three signed phase references into two duty values per phase for a three-level neutral-clamped inverter leg. The upper duty of a phase is measured from the smallest of the three references, and the lower duty is measured from the largest. Because both duties land in the same 0-to-1 range, the gate stage can compare all six against one shared triangular carrier. It does not need a separate carrier for each half of the dc link.

A signed offset word from an external midpoint-balancing regulator is added to every duty. Sums that leave the 0-to-1 range are clipped. A new sample is taken only when the input strobe is high. The six duties and an output strobe are registered and appear one cycle later. Between strobes the outputs hold their values. Producing the sine references and the offset is left to neighbouring blocks.

Top module: `tl_duty_calc`

## Requirements
- R1: While `rst_n` is low at a clock edge, all six duties become 0 and `duty_valid` becomes 0.
- R2: Each upper duty equals sat(2·(r_k − min) + 2·offset), where r_k, min and offset are raw Q1.15 counts, min is the smallest of the three references, and a duty count of 65535 stands for 1.0.
- R3: Each lower duty equals sat(65536 + 2·(r_k − max) + 2·offset), where max is the largest of the three references.
- R4: The same signed offset from `np_offset` enters both duties of all three phases. A positive offset raises every duty and a negative offset lowers every duty, each by twice the offset in counts, before clipping.
- R5: A sum below 0 gives a duty of 0. A sum above 65535 gives a duty of 65535.
- R6: A strobe on `ref_valid` at one clock edge makes the new duties and a one-cycle pulse on `duty_valid` visible after that same edge. `duty_valid` is low after any edge where `ref_valid` was low.
- R7: While `ref_valid` is low, changes on the references and the offset have no effect, and the six duties keep their last values.
- R8: With zero offset, the upper duty of the largest phase is never clipped while the spread between the largest and smallest reference stays below 32768 counts. This spread covers a modulation index up to 1.15.
- R9: With zero offset, at least one upper duty is 0 (the smallest phase) and at least one lower duty is 65535 (the largest phase).
- R10: When all three references are equal and the offset is zero, every upper duty is 0 and every lower duty is 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | Strobe; the references and offset are sampled at this edge |
| ref_a | input | 16 | Phase A reference, signed Q1.15 |
| ref_b | input | 16 | Phase B reference, signed Q1.15 |
| ref_c | input | 16 | Phase C reference, signed Q1.15 |
| np_offset | input | 16 | Midpoint balancing offset, signed Q1.15 |
| duty_valid | output | 1 | One-cycle pulse marking fresh duties |
| duty_a_hi | output | 16 | Phase A upper duty, unsigned (65535 = 1.0) |
| duty_a_lo | output | 16 | Phase A lower duty |
| duty_b_hi | output | 16 | Phase B upper duty |
| duty_b_lo | output | 16 | Phase B lower duty |
| duty_c_hi | output | 16 | Phase C upper duty |
| duty_c_lo | output | 16 | Phase C lower duty |

## Verification
On every cycle, the assertions check the following:
- the strobe timing;
- that the duties are held between strobes;
- that the extreme finder's minimum and maximum bound all three references;
- that, with zero offset, one upper duty sits at 0 and one lower duty at full scale.

Only the bench's directed samples can show the exact duty values. These samples cover:
- ordinary references;
- positive and negative offsets;
- clipping at both bounds;
- the widest unclipped spread;
- tied references;
- back-to-back strobes.

// File: rtl/tl_duty_pkg.sv
// Shared constants and types for the three-level duty calculator.
// Assumes the duty word is at least as wide as the reference word.
package tl_duty_pkg;

    // Selects which half-bridge duty a calculator instance produces.
    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_sel_e;

    localparam int DEF_REF_W  = 16;
    localparam int DEF_DUTY_W = 16;
    localparam int DEF_NUM_PH = 3;

endpackage

// File: rtl/tl_extreme.sv
// Finds the signed minimum and maximum of NUM_PH packed references.
// Purely combinational; the references are two's-complement words.
module tl_extreme #(
    parameter int NUM_PH = 3,
    parameter int REF_W  = 16
) (
    input  logic [NUM_PH*REF_W-1:0] refs_flat,
    output logic signed [REF_W-1:0] ext_min,
    output logic signed [REF_W-1:0] ext_max
);

    // Linear scan: keep the running smallest and largest value.
    always_comb begin
        logic signed [REF_W-1:0] cur;
        ext_min = $signed(refs_flat[REF_W-1:0]);
        ext_max = $signed(refs_flat[REF_W-1:0]);
        for (int i = 1; i < NUM_PH; i++) begin
            cur = $signed(refs_flat[i*REF_W +: REF_W]);
            if (cur < ext_min) ext_min = cur;
            if (cur > ext_max) ext_max = cur;
        end
    end

endmodule

// File: rtl/tl_duty_half.sv
// Computes one clipped duty word from a phase reference, the chosen
// extreme (minimum for the upper half, maximum for the lower half)
// and the balancing offset. Assumes DUTY_W >= REF_W; the reference
// is Q1.(REF_W-1), and the duty full scale is 2**DUTY_W - 1.
module tl_duty_half
    import tl_duty_pkg::*;
#(
    parameter int        REF_W  = 16,
    parameter int        DUTY_W = 16,
    parameter half_sel_e HALF   = HALF_UPPER
) (
    input  logic signed [REF_W-1:0] ref_k,
    input  logic signed [REF_W-1:0] ref_ext,
    input  logic signed [REF_W-1:0] offset,
    output logic [DUTY_W-1:0]       duty
);

    localparam int SHIFT = DUTY_W - REF_W + 1;
    localparam int SUM_W = DUTY_W + 4;
    localparam int PAD   = SUM_W - REF_W;
    localparam logic signed [SUM_W-1:0] FULL = SUM_W'((1 << DUTY_W) - 1);

    logic signed [SUM_W-1:0] ref_x, ext_x, off_x, bias, total;

    // Sign-extend the three operands to the working width.
    always_comb begin
        ref_x = {{PAD{ref_k[REF_W-1]}},   ref_k};
        ext_x = {{PAD{ref_ext[REF_W-1]}}, ref_ext};
        off_x = {{PAD{offset[REF_W-1]}},  offset};
    end

    // The lower half is lifted by one full unit so that its range is 0..1.
    generate
        if (HALF == HALF_LOWER) begin : g_lower
            assign bias = SUM_W'(1 << DUTY_W);
        end else begin : g_upper
            assign bias = '0;
        end
    endgenerate

    // Scale the difference and the offset into duty units, then add them.
    always_comb begin
        total = ((ref_x - ext_x) <<< SHIFT) + bias + (off_x <<< SHIFT);
    end

    // Clip the sum to the representable duty range.
    always_comb begin
        if (total < 0)
            duty = '0;
        else if (total > FULL)
            duty = FULL[DUTY_W-1:0];
        else
            duty = total[DUTY_W-1:0];
    end

endmodule

// File: rtl/tl_duty_calc.sv
// Three-level duty calculator: per phase, the upper duty is measured
// from the minimum reference and the lower duty from the maximum, so
// one shared carrier serves both halves. A balancing offset is added
// to every duty. Samples only on ref_valid; the outputs are registered
// and held. Synchronous active-low reset.
module tl_duty_calc
    import tl_duty_pkg::*;
#(
    parameter int REF_W  = DEF_REF_W,
    parameter int DUTY_W = DEF_DUTY_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_valid,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    input  logic signed [REF_W-1:0] np_offset,
    output logic                    duty_valid,
    output logic [DUTY_W-1:0]       duty_a_hi,
    output logic [DUTY_W-1:0]       duty_a_lo,
    output logic [DUTY_W-1:0]       duty_b_hi,
    output logic [DUTY_W-1:0]       duty_b_lo,
    output logic [DUTY_W-1:0]       duty_c_hi,
    output logic [DUTY_W-1:0]       duty_c_lo
);

    localparam int NUM_PH = DEF_NUM_PH;
    localparam logic [DUTY_W-1:0] DUTY_FULL = '1;

    logic [NUM_PH*REF_W-1:0]              refs_flat;
    logic signed [REF_W-1:0]              ext_min, ext_max;
    logic [NUM_PH-1:0][DUTY_W-1:0]        hi_next, lo_next;
    logic [NUM_PH-1:0][DUTY_W-1:0]        hi_q, lo_q;

    // Gather the phase references into one packed bus, phase A lowest.
    assign refs_flat = {ref_c, ref_b, ref_a};

    tl_extreme #(
        .NUM_PH (NUM_PH),
        .REF_W  (REF_W)
    ) u_extreme (
        .refs_flat (refs_flat),
        .ext_min   (ext_min),
        .ext_max   (ext_max)
    );

    // One upper and one lower duty calculator per phase.
    generate
        for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
            tl_duty_half #(
                .REF_W  (REF_W),
                .DUTY_W (DUTY_W),
                .HALF   (HALF_UPPER)
            ) u_hi (
                .ref_k   ($signed(refs_flat[p*REF_W +: REF_W])),
                .ref_ext (ext_min),
                .offset  (np_offset),
                .duty    (hi_next[p])
            );
            tl_duty_half #(
                .REF_W  (REF_W),
                .DUTY_W (DUTY_W),
                .HALF   (HALF_LOWER)
            ) u_lo (
                .ref_k   ($signed(refs_flat[p*REF_W +: REF_W])),
                .ref_ext (ext_max),
                .offset  (np_offset),
                .duty    (lo_next[p])
            );
        end
    endgenerate

    // Register the duties on a strobe and pulse the output valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_valid <= 1'b0;
            hi_q       <= '0;
            lo_q       <= '0;
        end else begin
            duty_valid <= ref_valid;
            if (ref_valid) begin
                hi_q <= hi_next;
                lo_q <= lo_next;
            end
        end
    end

    // Split the registered arrays onto the named ports.
    assign duty_a_hi = hi_q[0];
    assign duty_b_hi = hi_q[1];
    assign duty_c_hi = hi_q[2];
    assign duty_a_lo = lo_q[0];
    assign duty_b_lo = lo_q[1];
    assign duty_c_lo = lo_q[2];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) ref_valid |=> duty_valid); // R6
    AST_VALID_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) !ref_valid |=> !duty_valid); // R6
    AST_HOLD_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !ref_valid |=> ($stable(hi_q) && $stable(lo_q))); // R7
    AST_MIN_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) ref_valid |-> (ext_min <= ref_a && ext_min <= ref_b && ext_min <= ref_c)); // R2
    AST_MAX_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) ref_valid |-> (ext_max >= ref_a && ext_max >= ref_b && ext_max >= ref_c)); // R3
    AST_ZERO_ANCHOR:   assert property (@(posedge clk) disable iff (!rst_n) (ref_valid && np_offset == '0) |=> ((hi_q[0] == '0 || hi_q[1] == '0 || hi_q[2] == '0) && (lo_q[0] == DUTY_FULL || lo_q[1] == DUTY_FULL || lo_q[2] == DUTY_FULL))); // R9

endmodule

// File: tb/tl_duty_calc_test.sv
module tl_duty_calc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_valid = 1'b0;
    logic signed [15:0] ref_a = '0, ref_b = '0, ref_c = '0, np_offset = '0;
    logic        duty_valid;
    logic [15:0] duty_a_hi, duty_a_lo, duty_b_hi, duty_b_lo, duty_c_hi, duty_c_lo;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tl_duty_calc uut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .np_offset(np_offset),
        .duty_valid(duty_valid),
        .duty_a_hi(duty_a_hi), .duty_a_lo(duty_a_lo),
        .duty_b_hi(duty_b_hi), .duty_b_lo(duty_b_lo),
        .duty_c_hi(duty_c_hi), .duty_c_lo(duty_c_lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clip(input int v);
        if (v < 0) return 0;
        if (v > 65535) return 65535;
        return v;
    endfunction

    // Applies one strobe, then checks all six duties against the R2/R3 formulas.
    task automatic apply_and_check(input string req, input int a, input int b,
                                   input int c, input int off);
        int mn, mx;
        int ra, rb, rc;
        ra = a; rb = b; rc = c;
        mn = ra; if (rb < mn) mn = rb; if (rc < mn) mn = rc;
        mx = ra; if (rb > mx) mx = rb; if (rc > mx) mx = rc;
        @(negedge clk);
        ref_a = 16'(a); ref_b = 16'(b); ref_c = 16'(c); np_offset = 16'(off);
        ref_valid = 1'b1;
        @(posedge clk); #2;
        chk({req, " R6 valid"}, int'(duty_valid), 1);
        chk({req, " R2 a_hi"}, int'(duty_a_hi), clip(2*(ra-mn) + 2*off));
        chk({req, " R2 b_hi"}, int'(duty_b_hi), clip(2*(rb-mn) + 2*off));
        chk({req, " R2 c_hi"}, int'(duty_c_hi), clip(2*(rc-mn) + 2*off));
        chk({req, " R3 a_lo"}, int'(duty_a_lo), clip(65536 + 2*(ra-mx) + 2*off));
        chk({req, " R3 b_lo"}, int'(duty_b_lo), clip(65536 + 2*(rb-mx) + 2*off));
        chk({req, " R3 c_lo"}, int'(duty_c_lo), clip(65536 + 2*(rc-mx) + 2*off));
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(posedge clk); #2;
        chk("R1 valid", int'(duty_valid), 0);
        chk("R1 a_hi", int'(duty_a_hi), 0);
        chk("R1 c_lo", int'(duty_c_lo), 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_basic();
        apply_and_check("basic", 10000, -5000, -3000, 0);
        chk("R9 min phase hi", int'(duty_b_hi), 0);
        chk("R9 max phase lo", int'(duty_a_lo), 65535);
        apply_and_check("basic2", -20000, 7000, 12000, 0);
    endtask

    task automatic t_offset();
        apply_and_check("R4 pos offset", 10000, -5000, -3000, 1000);
        chk("R4 b_hi raised", int'(duty_b_hi), 2000);
        apply_and_check("R4 neg offset", 10000, -5000, -3000, -3000);
        chk("R4 a_lo lowered", int'(duty_a_lo), 65536 - 6000);
    endtask

    task automatic t_saturate();
        apply_and_check("R5 sat", 32767, -32768, 0, 0);
        chk("R5 top clip", int'(duty_a_hi), 65535);
        chk("R5 bottom clip", int'(duty_b_lo), 0);
        apply_and_check("R5 offset clip", 100, -100, 0, -32768);
    endtask

    task automatic t_linear();
        apply_and_check("R8 edge", 16383, -16384, 0, 0);
        chk("R8 unclipped", int'(duty_a_hi), 65534);
    endtask

    task automatic t_ties();
        apply_and_check("R10 ties", 1234, 1234, 1234, 0);
        chk("R10 hi zero", int'(duty_c_hi), 0);
        chk("R10 lo full", int'(duty_b_lo), 65535);
    endtask

    task automatic t_hold();
        int keep_a, keep_lo;
        apply_and_check("R7 pre", 5000, -2000, 1000, 0);
        keep_a = int'(duty_a_hi);
        keep_lo = int'(duty_b_lo);
        @(negedge clk);
        ref_a = 16'sd30000; ref_b = -16'sd30000; np_offset = 16'sd500;
        @(posedge clk); #2;
        chk("R6 valid low", int'(duty_valid), 0);
        @(posedge clk); #2;
        chk("R7 a_hi held", int'(duty_a_hi), keep_a);
        chk("R7 b_lo held", int'(duty_b_lo), keep_lo);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        ref_a = 16'sd100; ref_b = 16'sd0; ref_c = -16'sd100; np_offset = '0;
        ref_valid = 1'b1;
        @(posedge clk); #2;
        chk("R6 b2b first", int'(duty_a_hi), 400);
        @(negedge clk);
        ref_a = 16'sd0; ref_b = 16'sd300; ref_c = 16'sd0;
        @(posedge clk); #2;
        chk("R6 b2b valid", int'(duty_valid), 1);
        chk("R6 b2b second", int'(duty_b_hi), 600);
        @(negedge clk); ref_valid = 1'b0;
        @(posedge clk); #2;
        chk("R6 pulse ends", int'(duty_valid), 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_offset();
        t_saturate();
        t_linear();
        t_ties();
        t_hold();
        t_back_to_back();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule